// File: doc/BRIEF.md
# Watchdog Timer with Selectable Tick Rate

This block is a small up-counting watchdog. It advances by one on each pulse of a tick enable, and the tick comes from one of two enables that an external divider chain supplies. One enable pulses once per 1024 system clocks. The other pulses once per 16384 system clocks. A select bit chooses between them. Software must issue a clear command often enough to keep the counter from wrapping. If the counter wraps past its top value, the block emits a one-cycle chip reset request.

A configuration input, fixed when the chip is set up, turns the watchdog on or off. While it is off, the counter sits at zero and no request is ever made. The clear command does not realign the external prescaler. The first tick after a clear can therefore arrive at almost any moment. For that reason the guaranteed time to a reset request is 15 whole tick periods, not 16. With a 32 kHz clock on the 1024 tick, that is 468.75 ms.

The asynchronous reset takes effect at once. Its release is synchronised inside the block, so counting starts on the third rising clock edge after the reset input goes high.

Top module: `wdog_timer`

## Requirements
- R1: While rst_n is low, and after it returns high, wd_count reads 0 and rst_req reads 0 until ticks arrive.
- R2: While enabled, each clock edge with the selected tick high and no clear adds one to wd_count. Pulses on the tick input that is not selected leave wd_count unchanged.
- R3: slow_sel = 0 selects tick_div1k as the tick. slow_sel = 1 selects tick_div16k.
- R4: Changing slow_sel does not change wd_count. The new choice applies from the next tick.
- R5: A clock edge with kick high sets wd_count to 0, even when a selected tick arrives on the same edge, and no reset request follows from that edge.
- R6: A selected tick that arrives while wd_count is 15 makes rst_req high for exactly one cycle, starting on the next cycle. In that same cycle wd_count reads 0.
- R7: After a clear, 15 selected ticks leave wd_count at 15 with no request. The 16th selected tick produces the request.
- R8: While cfg_enable is 0, wd_count is held at 0 and rst_req stays 0, whatever the ticks do.
- R9: Taking rst_n low in the middle of a count sets wd_count and rst_req to 0 without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_enable | input | 1 | Configuration enable, 1 = watchdog active |
| slow_sel | input | 1 | Tick select, 0 = tick_div1k, 1 = tick_div16k |
| tick_div1k | input | 1 | One-cycle enable pulse every 1024 system clocks |
| tick_div16k | input | 1 | One-cycle enable pulse every 16384 system clocks |
| kick | input | 1 | Clear command from software |
| wd_count | output | 4 | Current watchdog count |
| rst_req | output | 1 | One-cycle chip reset request |

## Verification
The count is visible on wd_count, so a wrong internal count shows at the ports on the clock edge after it goes wrong:
- A missed or duplicated step shows up on the very next edge.
- A wrong choice of tick source shows up on the first pulse of the unselected tick input.
- A wrong overflow threshold or a stretched pulse shows up on rst_req within one cycle of the tick at count 15.

The reference model is compared against the block on every clock, so each of these faults is reported in the cycle it appears.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic {
    TICK_DIV1K  = 1'b0,
    TICK_DIV16K = 1'b1
  } tick_src_e;
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/wdog_tick_mux.sv
module wdog_tick_mux
  import wdog_pkg::*;
(
  input  logic      tick_div1k,
  input  logic      tick_div16k,
  input  tick_src_e src,
  output logic      tick
);
  always_comb begin
    unique case (src)
      TICK_DIV16K: tick = tick_div16k;
      default:     tick = tick_div1k;
    endcase
  end
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             clear,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             adv;

  always_comb begin
    adv   = enable && !clear && tick;
    wrap  = adv && (cnt_q == CNT_TOP);
    cnt_d = cnt_q;
    if (!enable || clear) cnt_d = '0;
    else if (adv)         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  logic pulse_q;
  logic pulse_d;

  always_comb begin
    pulse_d = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic             slow_sel,
  input  logic             tick_div1k,
  input  logic             tick_div16k,
  input  logic             kick,
  output logic [CNT_W-1:0] wd_count,
  output logic             rst_req
);
  logic      rst_sync_n;
  logic      tick_sel;
  logic      wrap;
  tick_src_e src;

  assign src = slow_sel ? TICK_DIV16K : TICK_DIV1K;

  wdog_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wdog_tick_mux u_tick_mux (
    .tick_div1k  (tick_div1k),
    .tick_div16k (tick_div16k),
    .src         (src),
    .tick        (tick_sel)
  );

  wdog_count #(.CNT_W(CNT_W)) u_count (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .enable (cfg_enable),
    .clear  (kick),
    .tick   (tick_sel),
    .count  (wd_count),
    .wrap   (wrap)
  );

  wdog_pulse u_pulse (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .fire  (wrap),
    .pulse (rst_req)
  );
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             cfg_enable,
  input logic             slow_sel,
  input logic             tick_div1k,
  input logic             tick_div16k,
  input logic             kick,
  input logic [CNT_W-1:0] wd_count,
  input logic             rst_req
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
  logic any_tick;
  assign any_tick = slow_sel ? tick_div16k : tick_div1k;

  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_ok)
    !cfg_enable |=> (wd_count == '0) && !rst_req);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_ok)
    rst_req |=> !rst_req);

  a_r6_zero_with_pulse: assert property (@(posedge clk) disable iff (!rst_ok)
    rst_req |-> (wd_count == '0));

  a_r5_kick_clears: assert property (@(posedge clk) disable iff (!rst_ok)
    kick |=> (wd_count == '0) && !rst_req);

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_ok)
    (cfg_enable && !kick && any_tick && wd_count != TOP) |=>
      (wd_count == $past(wd_count) + 1'b1) && !rst_req);

  a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_ok)
    (cfg_enable && !kick && !any_tick) |=> $stable(wd_count) && !rst_req);

  a_r6_wrap_fires: assert property (@(posedge clk) disable iff (!rst_ok)
    (cfg_enable && !kick && any_tick && wd_count == TOP) |=> rst_req);
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_ok      (rst_sync_n),
  .cfg_enable  (cfg_enable),
  .slow_sel    (slow_sel),
  .tick_div1k  (tick_div1k),
  .tick_div16k (tick_div16k),
  .kick        (kick),
  .wd_count    (wd_count),
  .rst_req     (rst_req)
);

// File: tb/wdog_timer_tb.sv
`timescale 1ns/1ps
module wdog_timer_tb;
  logic       clk;
  logic       rst_n;
  logic       cfg_enable;
  logic       slow_sel;
  logic       tick_div1k;
  logic       tick_div16k;
  logic       kick;
  logic [3:0] wd_count;
  logic       rst_req;

  int    checks;
  int    fails;
  bit    done;
  string phase;

  int m_cnt;
  int m_req;
  int m_rel;

  wdog_timer u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_enable  (cfg_enable),
    .slow_sel    (slow_sel),
    .tick_div1k  (tick_div1k),
    .tick_div16k (tick_div16k),
    .kick        (kick),
    .wd_count    (wd_count),
    .rst_req     (rst_req)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural reference: a wrap schedules a request in a one-entry queue
  int req_q[$];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_req = 0; m_rel = 0; req_q.delete();
    end else if (m_rel < 2) begin
      m_rel++; m_cnt = 0; m_req = 0;
    end else begin
      bit t;
      t = slow_sel ? tick_div16k : tick_div1k;
      m_req = (req_q.size() > 0) ? req_q.pop_front() : 0;
      if (!cfg_enable || kick) begin
        m_cnt = 0; req_q.push_back(0);
      end else if (t) begin
        if (m_cnt == 15) begin m_cnt = 0; req_q.push_back(1); end
        else begin m_cnt = m_cnt + 1; req_q.push_back(0); end
      end else req_q.push_back(0);
      m_req = (m_req == 1 && m_cnt == 0) ? 1 : 0;
    end
  end

  // the queue entry pushed this edge is the request seen after this edge
  function automatic int model_req();
    return (req_q.size() > 0) ? req_q[req_q.size()-1] : 0;
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (wd_count !== 4'(m_cnt) || rst_req !== model_req()[0]) begin
        fails++;
        $display("FAIL %s model compare: count=%0d req=%0b expected count=%0d req=%0d",
                 phase, wd_count, rst_req, m_cnt, model_req());
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input bit f, input bit s, input bit k);
    @(negedge clk); #1;
    tick_div1k = f; tick_div16k = s; kick = k;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0);
  endtask

  task automatic tick_n(input int n, input bit slow);
    for (int i = 0; i < n; i++) begin
      drive(!slow, slow, 0);
      idle(2);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired in phase %s actual=hung expected=done", phase);
    finish_run();
  end

  initial begin
    checks = 0; fails = 0; done = 1'b0; phase = "R1";
    rst_n = 1'b0; cfg_enable = 1'b1; slow_sel = 1'b0;
    tick_div1k = 1'b0; tick_div16k = 1'b0; kick = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 count in reset", wd_count, 0);
    check("R1 req in reset", rst_req, 0);
    #1 rst_n = 1'b1;
    idle(4);
    check("R1 count after release", wd_count, 0);
    check("R1 req after release", rst_req, 0);

    phase = "R2";
    tick_n(5, 0);
    check("R2 five ticks", wd_count, 5);
    drive(0, 1, 0); idle(1);
    check("R2 unselected slow tick ignored", wd_count, 5);

    phase = "R3";
    drive(0, 0, 0); slow_sel = 1'b1;
    idle(1);
    check("R4 select change keeps count", wd_count, 5);
    drive(1, 0, 0); idle(1);
    check("R3 fast tick ignored when slow selected", wd_count, 5);
    tick_n(3, 1);
    check("R3 slow ticks counted", wd_count, 8);
    slow_sel = 1'b0;
    idle(1);
    check("R4 back to fast keeps count", wd_count, 8);

    phase = "R5";
    drive(1, 0, 1); idle(1);
    check("R5 kick beats tick", wd_count, 0);
    tick_n(15, 0);
    check("R5 count after kick then 15 ticks", wd_count, 15);
    drive(1, 0, 1); idle(1);
    check("R5 kick at top gives zero", wd_count, 0);
    check("R5 kick at top gives no request", rst_req, 0);

    phase = "R7";
    tick_n(15, 0);
    check("R7 count after 15 ticks", wd_count, 15);
    check("R7 no request after 15 ticks", rst_req, 0);
    drive(1, 0, 0); idle(1);
    check("R6 request after 16th tick", rst_req, 1);
    check("R6 count zero with request", wd_count, 0);
    idle(1);
    check("R6 request lasts one cycle", rst_req, 0);

    phase = "R6";
    slow_sel = 1'b1;
    tick_n(16, 1);
    check("R6 slow-tick wrap count", wd_count, 0);

    phase = "R8";
    tick_n(6, 1);
    drive(0, 0, 0); cfg_enable = 1'b0;
    idle(1);
    check("R8 disable zeroes count", wd_count, 0);
    tick_n(20, 1);
    check("R8 count held while disabled", wd_count, 0);
    check("R8 no request while disabled", rst_req, 0);
    cfg_enable = 1'b1;

    phase = "R9";
    tick_n(7, 1);
    check("R9 count before async reset", wd_count, 7);
    @(negedge clk); #2 rst_n = 1'b0;
    #1;
    check("R9 count cleared without edge", wd_count, 0);
    check("R9 request low in reset", rst_req, 0);
    @(negedge clk); #1 rst_n = 1'b1;
    idle(3);
    check("R1 count after second release", wd_count, 0);
    finish_run();
  end
endmodule